// File: doc/BRIEF.md
# One-Wire Bus Slot Timing Engine

This block is the low-level master for a one-wire open-drain bus. It runs exactly one bus operation per command. The operation is one of four: a reset with presence detection, a slot that writes a one, a slot that writes a zero, or a slot that reads one bit. The block never drives the line high. It only turns on a pull-low enable, and a resistor outside the block pulls the line back up. The line level it reads comes through a two-flop synchronizer.

All slot and reset durations arrive as runtime inputs counted in microseconds. A prescaler divides the system clock into a 1 µs time base. The prescaler is restarted when a command is accepted, so every duration maps to a whole number of clocks. When an operation ends, the block raises a one-clock done pulse. The read bit, the presence flag and the wiring-error flag then hold their values until the next command is accepted. Higher layers build bytes, ROM searches and CRC checks on top of this block.

Top module: `ow_slot_engine`

## Requirements
- R1: One microsecond equals CLK_PER_US clocks. For a write-1 or write-0 slot, done_o rises CLK_PER_US*(t_slot_i+t_rec_i) clocks after the accepting edge.
- R2: Command 2'b10 (write 1) drives line_oe_o for exactly CLK_PER_US*t_low1_i clocks, starting right after the accepting edge. All result flags read 0 afterwards.
- R3: Command 2'b01 (write 0) drives line_oe_o for exactly CLK_PER_US*t_low0_i clocks. All result flags read 0 afterwards.
- R4: Command 2'b11 (read) drives line_oe_o for CLK_PER_US*t_low_rd_i clocks and then polls the synchronized line. rd_bit_o is 1 when the line is seen high while fewer than t_rdv_i µs have passed since the falling edge. done_o follows the falling edge by CLK_PER_US*(t_slot_i+t_rec_i) clocks.
- R5: A read returns 0 when the line first reads high at or after t_rdv_i µs. It also returns 0 when the line is still low at t_rdv_i+2 µs, which is where polling stops.
- R6: Command 2'b00 (reset) is aborted when the synchronized line is low at acceptance. line_oe_o is never asserted, and wire_err_o and done_o are set in the same edge.
- R7: A reset drives line_oe_o for CLK_PER_US*t_rstl_i clocks and then releases the line. At t_pdh_i+t_pdl_i/2 µs after release, presence_o takes the inverse of the line level. done_o follows the accept by CLK_PER_US*(t_rstl_i+t_rsth_i) clocks.
- R8: If the line is still low t_rsth_i µs after a reset releases it, wire_err_o is set.
- R9: cmd_valid_i is ignored while busy_o is high. done_o lasts one clock. The result flags are cleared when a command is accepted and are stable while idle.
- R10: line_oe_o is only ever high while busy_o is high. The line input passes through two synchronizer flops before it is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command strobe, taken only when idle |
| cmd_i | input | 2 | 00 reset, 01 write 0, 10 write 1, 11 read |
| t_low1_i | input | US_W | Low time of a write-1 slot, µs |
| t_low0_i | input | US_W | Low time of a write-0 slot, µs |
| t_low_rd_i | input | US_W | Low time of a read slot, µs |
| t_slot_i | input | US_W | Slot length, µs |
| t_rec_i | input | US_W | Recovery time after a slot, µs |
| t_rdv_i | input | US_W | Read data valid time, µs |
| t_rstl_i | input | US_W | Reset low time, µs |
| t_rsth_i | input | US_W | Reset release window, µs |
| t_pdh_i | input | US_W | Presence high wait, µs |
| t_pdl_i | input | US_W | Presence low length, µs |
| line_i | input | 1 | Raw bus line level |
| line_oe_o | output | 1 | Pull-low enable for the open-drain driver |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-clock completion pulse |
| rd_bit_o | output | 1 | Bit returned by the last read slot |
| presence_o | output | 1 | A device answered the last reset |
| wire_err_o | output | 1 | Line found stuck low during a reset |

## Verification
Every result is due at a fixed number of clocks after the edge that accepts the command. Done comes CLK_PER_US times the slot-plus-recovery sum after that edge, or CLK_PER_US times the reset low-plus-release sum. For a stuck line it comes in the accepting edge itself. The pull-low width is exactly CLK_PER_US times the relevant low time. For each command, the driver queues its expected latency, low width and flags, and records the clock count at the accepting edge. The monitor samples on falling edges, counts pull-low clocks, and on each done pulse compares the measured latency and width against the queued item. The slave model releases the line well away from the t_rdv_i and presence sample instants, so the two-clock synchronizer lag cannot move a result across a boundary.

// File: rtl/ow_pkg.sv
package ow_pkg;
  typedef enum logic [1:0] {
    OW_RESET = 2'b00,
    OW_WR0   = 2'b01,
    OW_WR1   = 2'b10,
    OW_READ  = 2'b11
  } ow_cmd_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOW,
    S_WREC,
    S_RPOLL,
    S_RHOLD,
    S_RST_LOW,
    S_RST_PRES,
    S_RST_TAIL
  } ow_state_e;
endpackage

// File: rtl/ow_us_tick.sv
module ow_us_tick #(
  parameter int CLK_PER_US = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [PW-1:0] LAST = PW'(CLK_PER_US - 1);

  logic [PW-1:0] pre_q;

  assign tick_o = (pre_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre_q <= '0;
    else if (clr_i)   pre_q <= '0;
    else if (tick_o)  pre_q <= '0;
    else              pre_q <= pre_q + 1'b1;
  end

  generate
    if (CLK_PER_US > 1) begin : g_gap
      p_tick_gap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/ow_sync.sv
module ow_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ow_slot_fsm.sv
module ow_slot_fsm
  import ow_pkg::*;
#(
  parameter int US_W = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            line_s_i,
  input  logic            cmd_valid_i,
  input  logic [1:0]      cmd_i,
  input  logic [US_W-1:0] t_low1_i,
  input  logic [US_W-1:0] t_low0_i,
  input  logic [US_W-1:0] t_low_rd_i,
  input  logic [US_W-1:0] t_slot_i,
  input  logic [US_W-1:0] t_rec_i,
  input  logic [US_W-1:0] t_rdv_i,
  input  logic [US_W-1:0] t_rstl_i,
  input  logic [US_W-1:0] t_rsth_i,
  input  logic [US_W-1:0] t_pdh_i,
  input  logic [US_W-1:0] t_pdl_i,
  output logic            accept_o,
  output logic            line_oe_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            rd_bit_o,
  output logic            presence_o,
  output logic            wire_err_o
);
  localparam int EW = US_W + 2;

  ow_state_e    state_q;
  ow_cmd_e      cmd_q;
  ow_cmd_e      cmd_in;
  logic [EW-1:0] el_q, el_nxt;
  logic [EW-1:0] low_lim, slot_end, rdv_lim, poll_end, pres_at, rstl_lim, rsth_lim;

  assign cmd_in   = ow_cmd_e'(cmd_i);
  assign busy_o   = (state_q != S_IDLE);
  assign accept_o = !busy_o && cmd_valid_i;
  assign el_nxt   = el_q + EW'(tick_i);

  always_comb begin
    unique case (cmd_q)
      OW_WR1:  low_lim = EW'(t_low1_i);
      OW_WR0:  low_lim = EW'(t_low0_i);
      default: low_lim = EW'(t_low_rd_i);
    endcase
  end

  assign slot_end = EW'(t_slot_i) + EW'(t_rec_i);
  assign rdv_lim  = EW'(t_rdv_i);
  assign poll_end = EW'(t_rdv_i) + EW'(2);
  assign pres_at  = EW'(t_pdh_i) + EW'(t_pdl_i / 2);
  assign rstl_lim = EW'(t_rstl_i);
  assign rsth_lim = EW'(t_rsth_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      cmd_q      <= OW_RESET;
      el_q       <= '0;
      line_oe_o  <= 1'b0;
      done_o     <= 1'b0;
      rd_bit_o   <= 1'b0;
      presence_o <= 1'b0;
      wire_err_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (cmd_valid_i) begin
            cmd_q      <= cmd_in;
            el_q       <= '0;
            rd_bit_o   <= 1'b0;
            presence_o <= 1'b0;
            wire_err_o <= 1'b0;
            if (cmd_in == OW_RESET && !line_s_i) begin
              // stuck-low bus: abort without driving
              wire_err_o <= 1'b1;
              done_o     <= 1'b1;
            end else begin
              line_oe_o <= 1'b1;
              state_q   <= (cmd_in == OW_RESET) ? S_RST_LOW : S_LOW;
            end
          end
        end
        S_LOW: begin
          el_q <= el_nxt;
          if (el_nxt >= low_lim) begin
            line_oe_o <= 1'b0;
            state_q   <= (cmd_q == OW_READ) ? S_RPOLL : S_WREC;
          end
        end
        S_WREC: begin
          el_q <= el_nxt;
          if (el_nxt >= slot_end) begin
            done_o  <= 1'b1;
            state_q <= S_IDLE;
          end
        end
        S_RPOLL: begin
          el_q <= el_nxt;
          if (line_s_i) begin
            rd_bit_o <= (el_q < rdv_lim);
            state_q  <= S_RHOLD;
          end else if (el_nxt >= poll_end) begin
            rd_bit_o <= 1'b0;
            state_q  <= S_RHOLD;
          end
        end
        S_RHOLD: begin
          el_q <= el_nxt;
          if (el_nxt >= slot_end) begin
            done_o  <= 1'b1;
            state_q <= S_IDLE;
          end
        end
        S_RST_LOW: begin
          el_q <= el_nxt;
          if (el_nxt >= rstl_lim) begin
            line_oe_o <= 1'b0;
            el_q      <= '0;
            state_q   <= S_RST_PRES;
          end
        end
        S_RST_PRES: begin
          el_q <= el_nxt;
          if (el_nxt >= pres_at) begin
            presence_o <= !line_s_i;
            state_q    <= S_RST_TAIL;
          end
        end
        S_RST_TAIL: begin
          el_q <= el_nxt;
          if (el_nxt >= rsth_lim) begin
            wire_err_o <= !line_s_i;
            done_o     <= 1'b1;
            state_q    <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  p_drive_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !line_oe_o);

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_flags_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !$past(busy_o) && !$past(accept_o))
      |-> $stable({rd_bit_o, presence_o, wire_err_o}));

  p_stuck_nodrive_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && cmd_i == 2'b00 && !line_s_i) |=> (!line_oe_o && done_o && wire_err_o));

  p_ignore_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cmd_valid_i) |=> $stable(cmd_q));
endmodule

// File: rtl/ow_slot_engine.sv
module ow_slot_engine #(
  parameter int CLK_PER_US = 100,
  parameter int US_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_valid_i,
  input  logic [1:0]      cmd_i,
  input  logic [US_W-1:0] t_low1_i,
  input  logic [US_W-1:0] t_low0_i,
  input  logic [US_W-1:0] t_low_rd_i,
  input  logic [US_W-1:0] t_slot_i,
  input  logic [US_W-1:0] t_rec_i,
  input  logic [US_W-1:0] t_rdv_i,
  input  logic [US_W-1:0] t_rstl_i,
  input  logic [US_W-1:0] t_rsth_i,
  input  logic [US_W-1:0] t_pdh_i,
  input  logic [US_W-1:0] t_pdl_i,
  input  logic            line_i,
  output logic            line_oe_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            rd_bit_o,
  output logic            presence_o,
  output logic            wire_err_o
);
  logic tick;
  logic line_s;
  logic accept;

  ow_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (accept),
    .tick_o(tick)
  );

  ow_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_i),
    .q_o   (line_s)
  );

  ow_slot_fsm #(.US_W(US_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .line_s_i   (line_s),
    .cmd_valid_i(cmd_valid_i),
    .cmd_i      (cmd_i),
    .t_low1_i   (t_low1_i),
    .t_low0_i   (t_low0_i),
    .t_low_rd_i (t_low_rd_i),
    .t_slot_i   (t_slot_i),
    .t_rec_i    (t_rec_i),
    .t_rdv_i    (t_rdv_i),
    .t_rstl_i   (t_rstl_i),
    .t_rsth_i   (t_rsth_i),
    .t_pdh_i    (t_pdh_i),
    .t_pdl_i    (t_pdl_i),
    .accept_o   (accept),
    .line_oe_o  (line_oe_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .rd_bit_o   (rd_bit_o),
    .presence_o (presence_o),
    .wire_err_o (wire_err_o)
  );
endmodule

// File: tb/ow_slot_engine_tb_top.sv
module ow_slot_engine_tb_top;
  localparam int P    = 4;
  localparam int US_W = 12;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd = 2'b00;
  logic line;
  logic oe, busy, done, rd_bit, pres, err;

  logic [US_W-1:0] t_low1 = 2, t_low0 = 12, t_lowr = 2, t_slot = 20, t_rec = 3;
  logic [US_W-1:0] t_rdv = 10, t_rstl = 40, t_rsth = 30, t_pdh = 3, t_pdl = 8;

  int cyc = 0;
  int n_run = 0, n_fail = 0;
  int low_cnt = 0;
  bit finished = 0;

  // slave model
  bit short_gnd = 0;
  bit on_fall = 0;
  int s_dly = 0, s_len = 0;
  int scnt = 0;
  logic oe_q = 1'b0;
  logic slave_low;

  typedef struct {
    int    c0;
    int    lat;
    int    low;
    bit    eb;
    bit    ep;
    bit    ee;
    string tag;
  } exp_t;
  exp_t q[$];

  ow_slot_engine #(.CLK_PER_US(P), .US_W(US_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .t_low1_i(t_low1), .t_low0_i(t_low0), .t_low_rd_i(t_lowr),
    .t_slot_i(t_slot), .t_rec_i(t_rec), .t_rdv_i(t_rdv),
    .t_rstl_i(t_rstl), .t_rsth_i(t_rsth), .t_pdh_i(t_pdh), .t_pdl_i(t_pdl),
    .line_i(line), .line_oe_o(oe), .busy_o(busy), .done_o(done),
    .rd_bit_o(rd_bit), .presence_o(pres), .wire_err_o(err)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc  <= cyc + 1;
    oe_q <= oe;
    if (on_fall ? (oe_q && !oe) : (!oe_q && oe)) scnt <= 0;
    else if (scnt < 100000) scnt <= scnt + 1;
  end

  assign slave_low = (s_len > 0) && (scnt >= s_dly) && (scnt < s_dly + s_len);
  assign line = !(oe || slave_low || short_gnd);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp_v);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_ni) begin
      if (oe) low_cnt++;
      if (done) begin
        if (q.size() == 0) begin
          chk(0, "R9", "unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(cyc - e.c0 == e.lat, e.tag, "latency", cyc - e.c0, e.lat);
          chk(low_cnt == e.low, e.tag, "low width", low_cnt, e.low);
          chk({rd_bit, pres, err} == {e.eb, e.ep, e.ee}, e.tag, "flags",
              int'({rd_bit, pres, err}), int'({e.eb, e.ep, e.ee}));
        end
        low_cnt = 0;
      end
    end
  end

  task automatic issue_nw(input logic [1:0] c, input int lat, input int low,
                          input bit eb, input bit ep, input bit ee, input string tag);
    exp_t e;
    @(negedge clk);
    cmd = c;
    cmd_valid = 1'b1;
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
    e.c0 = cyc; e.lat = lat; e.low = low; e.eb = eb; e.ep = ep; e.ee = ee; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wait_idle();
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic issue(input logic [1:0] c, input int lat, input int low,
                       input bit eb, input bit ep, input bit ee, input string tag);
    issue_nw(c, lat, low, eb, ep, ee, tag);
    wait_idle();
  endtask

  localparam int SLOT_LAT = P * 23;
  localparam int RST_LAT  = P * 70;

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk({oe, busy, done, rd_bit, pres, err} == 6'b0, "R10", "reset state",
        int'({oe, busy, done, rd_bit, pres, err}), 0);

    // writes
    issue(2'b10, SLOT_LAT, P * 2, 0, 0, 0, "R2");
    issue(2'b01, SLOT_LAT, P * 12, 0, 0, 0, "R3");
    t_low1 = 5;
    issue(2'b10, SLOT_LAT, P * 5, 0, 0, 0, "R1");
    t_low1 = 2;

    // reads
    on_fall = 0;
    s_dly = 0; s_len = 0;
    issue(2'b11, SLOT_LAT, P * 2, 1, 0, 0, "R4");
    s_len = 30;
    issue(2'b11, SLOT_LAT, P * 2, 1, 0, 0, "R4");
    // flags held while idle
    repeat (30) @(negedge clk);
    chk(rd_bit == 1'b1, "R9", "rd_bit held", rd_bit, 1);
    s_len = 42;
    issue(2'b11, SLOT_LAT, P * 2, 0, 0, 0, "R5");
    s_len = 90;
    issue(2'b11, SLOT_LAT, P * 2, 0, 0, 0, "R5");
    s_len = 0;

    // flag cleared on accept, busy commands ignored
    issue(2'b11, SLOT_LAT, P * 2, 1, 0, 0, "R4");
    issue_nw(2'b01, SLOT_LAT, P * 12, 0, 0, 0, "R9");
    chk(rd_bit == 1'b0, "R9", "rd_bit cleared on accept", rd_bit, 0);
    repeat (10) @(negedge clk);
    cmd = 2'b11;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(oe == 1'b1, "R9", "oe kept during ignored cmd", oe, 1);
    wait_idle();

    // resets
    on_fall = 1;
    s_len = 0;
    issue(2'b00, RST_LAT, P * 40, 0, 0, 0, "R7");
    s_dly = 8; s_len = 40;
    issue(2'b00, RST_LAT, P * 40, 0, 1, 0, "R7");
    s_len = 300;
    issue(2'b00, RST_LAT, P * 40, 0, 1, 1, "R8");
    s_len = 0;
    repeat (5) @(negedge clk);
    short_gnd = 1;
    repeat (5) @(negedge clk);
    issue(2'b00, 0, 0, 0, 0, 1, "R6");
    chk(busy == 1'b0, "R6", "no busy on stuck line", busy, 0);
    short_gnd = 0;
    repeat (5) @(negedge clk);
    issue(2'b10, SLOT_LAT, P * 2, 0, 0, 0, "R10");

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule